// File: doc/BRIEF.md
# Link-Aggregation Egress Filter

This block trims the egress port vector of a switched frame so that each link-aggregation group transmits the frame on exactly one of its member links. It holds two small register tables. The first is a group mapping table with one entry per group number. Each entry lists every egress port that leads to a member of that group. This includes the inter-chip link port when a member sits on another chip. The second is a set of eight hash-bucket masks, one per flow hash bucket.

For each lookup, the forwarding logic supplies three things: the destination port vector, the frame's three-bit flow bucket, and an optional destination group number. If the group number is flagged valid, the block widens the destination vector with that group's mapping entry. It then ANDs the result with the mask of the frame's bucket. Software programs the masks so that each group keeps one member per bucket. Ports that belong to no group are set in every mask, so they always pass.

The filter path is purely combinational. Both tables are written through 16-bit write words, and each write takes effect on the following clock cycle.

Top module: `lag_egress_filter`

## Requirements
- R1: After reset every group mapping entry is zero and every bucket mask is all ones, so the egress vector equals the destination vector for every bucket and group.
- R2: A mask write with the hash flag set loads bucket `mask_wdata[14:12]` with `mask_wdata[NPORTS-1:0]`. The new mask is visible at the filter from the cycle after the write edge. Bits between `NPORTS` and 11 are ignored.
- R3: A mask write with the hash flag low leaves every bucket mask unchanged.
- R4: A mapping write loads group `map_wdata[14:11]` with `map_wdata[NPORTS-1:0]`, visible from the cycle after the write edge. The remaining bits are ignored.
- R5: The egress vector equals (`dest_vec` OR the mapping entry of `grp_id`, when `grp_valid` is high) AND the mask of `bucket`.
- R6: With `grp_valid` low, the mapping table has no effect, and the egress vector is a subset of `dest_vec`.
- R7: A mask write and a mapping write in the same cycle both take effect.
- R8: With the masks programmed as a partition of a group's members across the eight buckets, a lookup to that group yields exactly one member port in every bucket.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_wr | input | 1 | Bucket mask write strobe |
| mask_hash | input | 1 | Hash-mode flag accompanying a mask write; the write is accepted only when high |
| mask_wdata | input | 16 | Mask write word: bucket in [14:12], port mask in [NPORTS-1:0] |
| map_wr | input | 1 | Group mapping write strobe |
| map_wdata | input | 16 | Mapping write word: group in [14:11], member vector in [NPORTS-1:0] |
| dest_vec | input | NPORTS | Destination port vector of the frame |
| bucket | input | 3 | Flow hash bucket of the frame |
| grp_valid | input | 1 | Frame is destined to an aggregation group |
| grp_id | input | 4 | Destination group number |
| egress_vec | output | NPORTS | Filtered egress port vector |

## Verification
The bench builds the block with its default of eleven ports and sixteen groups. With these values the mask port field ends just below the unused bit 11, and the mapping port field ends directly under the group number. Random write words therefore exercise both ignored-bit boundaries as well as the field decodes. Random writes to all 8 buckets and all 16 groups, interleaved with lookups, are compared against a table model. A directed three-member group spread over the buckets confirms that one member is chosen per bucket while non-member ports keep passing.

// File: rtl/lag_egress_filter.sv
module lag_egress_filter #(
  parameter int NPORTS  = 11,
  parameter int NGROUPS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              mask_hash,
  input  logic [15:0]       mask_wdata,
  input  logic              map_wr,
  input  logic [15:0]       map_wdata,
  input  logic [NPORTS-1:0] dest_vec,
  input  logic [2:0]        bucket,
  input  logic              grp_valid,
  input  logic [3:0]        grp_id,
  output logic [NPORTS-1:0] egress_vec
);
  localparam int NBKT = 8;
  localparam int GW   = $clog2(NGROUPS);

  logic [NPORTS-1:0] mask_q [NBKT];
  logic [NPORTS-1:0] map_q  [NGROUPS];

  wire [2:0]        wr_bkt  = mask_wdata[14:12];
  wire [GW-1:0]     wr_grp  = map_wdata[11 +: GW];
  wire [NPORTS-1:0] grp_vec = grp_valid ? map_q[grp_id[GW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBKT; b++) mask_q[b] <= '1;
    end else if (mask_wr && mask_hash) begin
      mask_q[wr_bkt] <= mask_wdata[NPORTS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGROUPS; g++) map_q[g] <= '0;
    end else if (map_wr) begin
      map_q[wr_grp] <= map_wdata[NPORTS-1:0];
    end
  end

  assign egress_vec = (dest_vec | grp_vec) & mask_q[bucket];

  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && mask_hash) |=> mask_q[$past(wr_bkt)] == $past(mask_wdata[NPORTS-1:0]));

  a_r3_hashless_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_hash) |=> mask_q[$past(wr_bkt)] == $past(mask_q[wr_bkt]));

  a_r4_map_load: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> map_q[$past(wr_grp)] == $past(map_wdata[NPORTS-1:0]));

  a_r5_within_targets: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> (egress_vec & ~(dest_vec | map_q[grp_id[GW-1:0]])) == '0);

  a_r6_no_group_subset: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |-> (egress_vec & ~dest_vec) == '0);

endmodule

// File: tb/lag_egress_filter_test.sv
module lag_egress_filter_test;
  localparam int NP = 11;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          mask_wr = 0, mask_hash = 0, map_wr = 0;
  logic [15:0]   mask_wdata = '0, map_wdata = '0;
  logic [NP-1:0] dest_vec = '0;
  logic [2:0]    bucket = '0;
  logic          grp_valid = 0;
  logic [3:0]    grp_id = '0;
  logic [NP-1:0] egress_vec;

  int total = 0, bad = 0;
  bit done = 0;

  logic [NP-1:0] m_mask [8];
  logic [NP-1:0] m_map  [16];

  always #5 clk = ~clk;

  lag_egress_filter #(.NPORTS(NP), .NGROUPS(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .mask_wr(mask_wr), .mask_hash(mask_hash), .mask_wdata(mask_wdata),
    .map_wr(map_wr), .map_wdata(map_wdata),
    .dest_vec(dest_vec), .bucket(bucket), .grp_valid(grp_valid), .grp_id(grp_id),
    .egress_vec(egress_vec));

  function automatic logic [NP-1:0] expect_vec(logic [NP-1:0] d, logic [2:0] b,
                                               logic v, logic [3:0] g);
    return (d | (v ? m_map[g] : '0)) & m_mask[b];
  endfunction

  task automatic look(input logic [NP-1:0] d, input logic [2:0] b,
                      input logic v, input logic [3:0] g, input string tag);
    logic [NP-1:0] e;
    @(negedge clk);
    dest_vec = d; bucket = b; grp_valid = v; grp_id = g;
    #2;
    e = expect_vec(d, b, v, g);
    total++;
    if (egress_vec !== e) begin
      bad++;
      $display("FAIL %s: egress=%h expected=%h", tag, egress_vec, e);
    end
  endtask

  task automatic do_write(input logic mw, input logic mh, input logic [15:0] md,
                          input logic pw, input logic [15:0] pd);
    @(negedge clk);
    mask_wr = mw; mask_hash = mh; mask_wdata = md;
    map_wr = pw; map_wdata = pd;
    @(posedge clk);
    if (mw && mh) m_mask[md[14:12]] = md[NP-1:0];
    if (pw) m_map[pd[14:11]] = pd[NP-1:0];
    @(negedge clk);
    mask_wr = 0; map_wr = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 8; b++) m_mask[b] = '1;
    for (int g = 0; g < 16; g++) m_map[g] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1: reset state passes destination unchanged
    for (int i = 0; i < 8; i++)
      look(NP'($urandom), 3'(i), 1'b1, 4'($urandom), "R1 reset");

    // R2: mask write, ignored bit 11 set
    do_write(1, 1, 16'h5800 | 16'h0155, 0, 16'h0);
    look('1, 3'd5, 0, 0, "R2 mask load");
    look('1, 3'd4, 0, 0, "R2 other bucket");

    // R3: hash flag low ignored
    do_write(1, 0, 16'h5000, 0, 16'h0);
    look('1, 3'd5, 0, 0, "R3 hashless write");

    // R4: mapping write with top bit set
    do_write(0, 0, 16'h0, 1, 16'hB800 | 16'h0213);
    look('0, 3'd2, 1, 4'd7, "R4 map load");
    look('0, 3'd5, 1, 4'd7, "R5 map and mask");

    // R6: group invalid ignores mapping
    look('0, 3'd2, 0, 4'd7, "R6 group invalid");

    // R7: simultaneous writes
    do_write(1, 1, 16'h27F0, 1, 16'h1000 | 16'h000F);
    look('0, 3'd2, 1, 4'd2, "R7 both writes");

    // R8: group 3 members ports 2,5,9 spread over buckets; others pass everywhere
    do_write(0, 0, 0, 1, {1'b0, 4'd3, 11'h224});
    for (int b = 0; b < 8; b++) begin
      logic [NP-1:0] mem;
      mem = (b < 3) ? 11'h004 : (b < 6) ? 11'h020 : 11'h200;
      do_write(1, 1, {1'b0, 3'(b), 1'b0, (~11'h224 | mem)}, 0, 0);
    end
    for (int b = 0; b < 8; b++) begin
      look('0, 3'(b), 1, 4'd3, "R8 one member");
      total++;
      if ($countones(egress_vec) != 1) begin
        bad++;
        $display("FAIL R8: egress=%h expected=one bit", egress_vec);
      end
      look(11'h003, 3'(b), 1, 4'd3, "R8 non-members pass");
    end

    // R5: random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 3);
      if (k == 0)
        do_write(1, 1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom));
      else
        look(NP'($urandom), 3'($urandom), 1'($urandom), 4'($urandom), "R5 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule